// File: doc/BRIEF.md
# Wake-Capable Interrupt Router

This block collects wake events from a small set of external pins and a few peripheral interrupt lines, for use while the rest of the chip is powered down or idle. Each wake pin goes through a two-flop synchronizer. A per-pin trigger mode then decides what counts as an event: a level, a single edge, either edge, or nothing at all. Each event sets a sticky status bit, and software clears that bit by writing a one to a clear register.

The block drives three kinds of output, all gated by one routing register. The first is a single shared interrupt for the wake pins, raised when a status bit is both enabled and routed. The second is one pass-through level per peripheral interrupt. The third is one combined system wake-up request. The wake-up request is built from latched pin status and live peripheral levels, each with its own wake-enable bit, and it does not depend on the interrupt enable register. Software reaches all of the state through a simple 32-bit register bus: a write takes effect at the clock edge, and read data is combinational from the address.

Top module: `wake_irq_router`

## Requirements
- R1: After reset, the status, enable and routing registers read zero, every pin configuration reads mode 4 (value 0x8 when the pin is low), and the outputs wake_irq, wake_req and perip_out are zero.
- R2: Registers sit at these offsets: status 0x310, enable 0x314, clear 0x318, routing 0x31C, and configuration for pin n at 0x330 + 8·n. Routing bits are pass-through 0..2, pin interrupt route 8+n, peripheral wake 16+i and pin wake 24+n. Bits that are not implemented, the clear register, and addresses that are not mapped all read zero.
- R3: Configuration bit 0 reads the synchronized pin level. It follows a pin change after two clock edges.
- R4: Mode 0 (level-low) and mode 1 (level-high) set the status bit while the level condition holds. Clearing the bit while the condition still holds leaves it set.
- R5: Mode 3 latches rising edges, mode 2 latches falling edges and mode 6 latches both. The status bit reads set three edges after the pin change and stays set until cleared. An edge in the opposite direction is ignored.
- R6: Mode 4, and the unused codes 5 and 7, never set status.
- R7: Writing the clear register clears exactly the status bits written as one. A status bit never drops without a clear.
- R8: wake_irq is high only when some pin has status, enable and route bit 8+n all set.
- R9: perip_out[i] equals perip_in[i] while routing bit i is set, and is zero otherwise.
- R10: wake_req is high when a status bit n with routing bit 24+n is set, or when perip_in[i] is high with routing bit 16+i set. The enable register does not affect it.
- R11: While configuration bit 4 is set, the pin latches no event. Releasing bit 4 after the pin has changed does not produce a stale edge.
- R12: Writes to the status register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access select |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| wake_pin | input | NUM_WAKE | Asynchronous wake pins |
| perip_in | input | NUM_PERIP | Peripheral interrupts, active high |
| perip_out | output | NUM_PERIP | Routed peripheral interrupts |
| wake_irq | output | 1 | Shared pin interrupt |
| wake_req | output | 1 | System wake-up request |

## Verification
Trigger detection is tried with a static high or low pin, with a single rising or falling transition, and with a full toggle. These patterns separate level modes, which set status again after a clear, from edge modes, which do not, and show that an opposite edge is ignored. A rising edge is sampled edge by edge to pin down the synchronizer and latch depth. Routing is tried with enable and route bits set independently, which shows that the interrupt needs both bits while the wake request ignores enable. Mode codes 5 and 7 and the hold bit are driven with pin toggles to show that no status appears.

// File: rtl/wakertr_pkg.sv
package wakertr_pkg;
    localparam int unsigned ADDR_W     = 12;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned MODE_W     = 3;

    localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h310;
    localparam logic [ADDR_W-1:0] OFS_ENABLE = 12'h314;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 12'h318;
    localparam logic [ADDR_W-1:0] OFS_ROUTE  = 12'h31C;
    localparam int unsigned       CFG_BASE   = 'h330;
    localparam int unsigned       CFG_STRIDE = 8;

    // routing field origins
    localparam int unsigned RT_PASS  = 0;
    localparam int unsigned RT_WIRQ  = 8;
    localparam int unsigned RT_PWAKE = 16;
    localparam int unsigned RT_SWAKE = 24;

    // trigger mode codes
    localparam logic [MODE_W-1:0] TRIG_LOW  = 3'd0;
    localparam logic [MODE_W-1:0] TRIG_HIGH = 3'd1;
    localparam logic [MODE_W-1:0] TRIG_FALL = 3'd2;
    localparam logic [MODE_W-1:0] TRIG_RISE = 3'd3;
    localparam logic [MODE_W-1:0] TRIG_OFF  = 3'd4;
    localparam logic [MODE_W-1:0] TRIG_ANY  = 3'd6;

    function automatic logic [ADDR_W-1:0] cfg_addr(input int unsigned n);
        return ADDR_W'(CFG_BASE + CFG_STRIDE * n);
    endfunction
endpackage

// File: rtl/wakertr_pin.sv
module wakertr_pin
    import wakertr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_raw,
    input  logic [MODE_W-1:0] mode,
    input  logic              hold,
    output logic              level,
    output logic              hit
);
    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } pin_st_t;

    pin_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pin_raw;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
        hit       = 1'b0;
        if (!hold) begin
            case (mode)
                TRIG_LOW:  hit = !st_q.sync;
                TRIG_HIGH: hit = st_q.sync;
                TRIG_FALL: hit = st_q.prev && !st_q.sync;
                TRIG_RISE: hit = !st_q.prev && st_q.sync;
                TRIG_ANY:  hit = st_q.prev ^ st_q.sync;
                default:   hit = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.sync;
endmodule

// File: rtl/wakertr_regs.sv
module wakertr_regs
    import wakertr_pkg::*;
#(
    parameter int unsigned NUM_WAKE  = 4,
    parameter int unsigned NUM_PERIP = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             reg_sel,
    input  logic                             reg_we,
    input  logic [ADDR_W-1:0]                reg_addr,
    input  logic [DATA_W-1:0]                reg_wdata,
    output logic [DATA_W-1:0]                reg_rdata,
    input  logic [NUM_WAKE-1:0]              pin_level,
    input  logic [NUM_WAKE-1:0]              pin_hit,
    output logic [NUM_WAKE-1:0]              status,
    output logic [NUM_WAKE-1:0]              enable,
    output logic [NUM_WAKE-1:0]              hold,
    output logic [NUM_WAKE-1:0][MODE_W-1:0]  mode,
    output logic [NUM_PERIP-1:0]             rt_pass,
    output logic [NUM_WAKE-1:0]              rt_wirq,
    output logic [NUM_PERIP-1:0]             rt_pwake,
    output logic [NUM_WAKE-1:0]              rt_swake
);
    localparam logic [DATA_W-1:0] P_ONES = DATA_W'((64'd1 << NUM_PERIP) - 64'd1);
    localparam logic [DATA_W-1:0] W_ONES = DATA_W'((64'd1 << NUM_WAKE) - 64'd1);
    localparam logic [DATA_W-1:0] ROUTE_MASK = (P_ONES << RT_PASS) | (W_ONES << RT_WIRQ)
                                             | (P_ONES << RT_PWAKE) | (W_ONES << RT_SWAKE);

    typedef struct packed {
        logic [NUM_WAKE-1:0]             status;
        logic [NUM_WAKE-1:0]             enable;
        logic [NUM_WAKE-1:0]             hold;
        logic [NUM_WAKE-1:0][MODE_W-1:0] mode;
        logic [DATA_W-1:0]               route;
    } regs_t;

    function automatic regs_t rst_val();
        regs_t v = '0;
        for (int n = 0; n < NUM_WAKE; n++) v.mode[n] = TRIG_OFF;
        return v;
    endfunction

    regs_t r_d, r_q;
    logic wr, rd;
    logic [NUM_WAKE-1:0] clr;

    always_comb begin
        wr  = reg_sel && reg_we;
        rd  = reg_sel && !reg_we;
        clr = '0;
        if (wr && reg_addr == OFS_CLEAR) clr = reg_wdata[NUM_WAKE-1:0];

        r_d        = r_q;
        // a new event wins over a clear in the same cycle
        r_d.status = (r_q.status & ~clr) | pin_hit;
        if (wr && reg_addr == OFS_ENABLE) r_d.enable = reg_wdata[NUM_WAKE-1:0];
        if (wr && reg_addr == OFS_ROUTE)  r_d.route  = reg_wdata & ROUTE_MASK;

        reg_rdata = '0;
        if (rd && reg_addr == OFS_STATUS) reg_rdata[NUM_WAKE-1:0] = r_q.status;
        if (rd && reg_addr == OFS_ENABLE) reg_rdata[NUM_WAKE-1:0] = r_q.enable;
        if (rd && reg_addr == OFS_ROUTE)  reg_rdata = r_q.route;

        for (int n = 0; n < NUM_WAKE; n++) begin
            if (reg_addr == cfg_addr(n)) begin
                if (wr) begin
                    r_d.mode[n] = reg_wdata[3:1];
                    r_d.hold[n] = reg_wdata[4];
                end
                if (rd) reg_rdata[4:0] = {r_q.hold[n], r_q.mode[n], pin_level[n]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= rst_val();
        else        r_q <= r_d;
    end

    assign status   = r_q.status;
    assign enable   = r_q.enable;
    assign hold     = r_q.hold;
    assign mode     = r_q.mode;
    assign rt_pass  = r_q.route[RT_PASS  +: NUM_PERIP];
    assign rt_wirq  = r_q.route[RT_WIRQ  +: NUM_WAKE];
    assign rt_pwake = r_q.route[RT_PWAKE +: NUM_PERIP];
    assign rt_swake = r_q.route[RT_SWAKE +: NUM_WAKE];
endmodule

// File: rtl/wake_irq_router.sv
module wake_irq_router
    import wakertr_pkg::*;
#(
    parameter int unsigned NUM_WAKE  = 4,
    parameter int unsigned NUM_PERIP = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_sel,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [NUM_WAKE-1:0]  wake_pin,
    input  logic [NUM_PERIP-1:0] perip_in,
    output logic [NUM_PERIP-1:0] perip_out,
    output logic                 wake_irq,
    output logic                 wake_req
);
    logic [NUM_WAKE-1:0]             level_w, hit_w, status_w, enable_w, hold_w;
    logic [NUM_WAKE-1:0][MODE_W-1:0] mode_w;
    logic [NUM_PERIP-1:0]            rt_pass_w, rt_pwake_w;
    logic [NUM_WAKE-1:0]             rt_wirq_w, rt_swake_w;

    for (genvar g = 0; g < NUM_WAKE; g++) begin : g_pin
        wakertr_pin u_pin (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_raw (wake_pin[g]),
            .mode    (mode_w[g]),
            .hold    (hold_w[g]),
            .level   (level_w[g]),
            .hit     (hit_w[g])
        );
    end

    wakertr_regs #(.NUM_WAKE(NUM_WAKE), .NUM_PERIP(NUM_PERIP)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_level (level_w),
        .pin_hit   (hit_w),
        .status    (status_w),
        .enable    (enable_w),
        .hold      (hold_w),
        .mode      (mode_w),
        .rt_pass   (rt_pass_w),
        .rt_wirq   (rt_wirq_w),
        .rt_pwake  (rt_pwake_w),
        .rt_swake  (rt_swake_w)
    );

    assign perip_out = perip_in & rt_pass_w;
    assign wake_irq  = |(status_w & enable_w & rt_wirq_w);
    assign wake_req  = (|(status_w & rt_swake_w)) | (|(perip_in & rt_pwake_w));
endmodule

// File: rtl/wakertr_chk.sv
module wakertr_chk
    import wakertr_pkg::*;
#(
    parameter int unsigned NW = 4,
    parameter int unsigned NP = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       reg_sel,
    input logic                       reg_we,
    input logic [ADDR_W-1:0]          reg_addr,
    input logic [NW-1:0]              clr_data,
    input logic [NW-1:0]              status,
    input logic [NW-1:0]              enable,
    input logic [NW-1:0]              hold,
    input logic [NW-1:0][MODE_W-1:0]  mode,
    input logic [NP-1:0]              rt_pass,
    input logic [NW-1:0]              rt_wirq,
    input logic [NP-1:0]              rt_pwake,
    input logic [NW-1:0]              rt_swake,
    input logic [NP-1:0]              perip_out,
    input logic                       wake_irq,
    input logic                       wake_req
);
    logic clr_wr;
    assign clr_wr = reg_sel && reg_we && (reg_addr == OFS_CLEAR);

    for (genvar n = 0; n < NW; n++) begin : g_pin_chk
        // R7
        status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            status[n] && !(clr_wr && clr_data[n]) |=> status[n]);
        // R6
        no_event_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status[n]) |-> ($past(mode[n]) != 3'd4) && ($past(mode[n]) != 3'd5)
                                 && ($past(mode[n]) != 3'd7));
        // R11
        no_event_when_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status[n]) |-> !$past(hold[n]));
    end

    // R8
    irq_needs_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |-> (|(status & enable & rt_wirq)));
    // R9
    pass_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (perip_out & ~rt_pass) == '0);
    // R10
    wake_needs_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> ((|rt_swake) || (|rt_pwake)));
endmodule

bind wake_irq_router wakertr_chk #(.NW(NUM_WAKE), .NP(NUM_PERIP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .clr_data  (reg_wdata[NUM_WAKE-1:0]),
    .status    (status_w),
    .enable    (enable_w),
    .hold      (hold_w),
    .mode      (mode_w),
    .rt_pass   (rt_pass_w),
    .rt_wirq   (rt_wirq_w),
    .rt_pwake  (rt_pwake_w),
    .rt_swake  (rt_swake_w),
    .perip_out (perip_out),
    .wake_irq  (wake_irq),
    .wake_req  (wake_req)
);

// File: tb/sim_wake_irq_router.sv
`timescale 1ns/1ps
module sim_wake_irq_router;
    localparam int NW = 4;
    localparam int NP = 3;
    localparam logic [11:0] A_ST = 12'h310, A_EN = 12'h314, A_CL = 12'h318, A_RT = 12'h31C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_sel = 1'b0, reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NW-1:0] wake_pin = '0;
    logic [NP-1:0] perip_in = '0;
    logic [NP-1:0] perip_out;
    logic wake_irq, wake_req;

    always #4 clk = ~clk;

    wake_irq_router #(.NUM_WAKE(NW), .NUM_PERIP(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wake_pin(wake_pin), .perip_in(perip_in), .perip_out(perip_out),
        .wake_irq(wake_irq), .wake_req(wake_req)
    );

    // kind: 0 read data, 1 wake_irq, 2 wake_req, 3 perip_out
    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       req;
    } sb_item_t;

    sb_item_t sb[$];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    function automatic logic [11:0] cfg(input int n);
        return 12'(12'h330 + 8 * n);
    endfunction

    // monitor: compares every queued expectation shortly after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                sb_item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0:       act = reg_rdata;
                    1:       act = {31'd0, wake_irq};
                    2:       act = {31'd0, wake_req};
                    default: act = {29'd0, perip_out};
                endcase
                n_tests++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: kind %0d actual 0x%08h expected 0x%08h",
                             it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1;
        reg_sel = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] e, input string req);
        sb_item_t it;
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
        it.kind = 0; it.exp = e; it.req = req;
        sb.push_back(it);
        #3;
        reg_sel = 1'b0;
    endtask

    task automatic out_chk(input int k, input logic [31:0] e, input string req);
        sb_item_t it;
        @(negedge clk);
        it.kind = k; it.exp = e; it.req = req;
        sb.push_back(it);
        #3;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk(A_ST, 32'h0, "R1 status");
        rd_chk(A_EN, 32'h0, "R1 enable");
        rd_chk(A_RT, 32'h0, "R1 route");
        rd_chk(cfg(0), 32'h8, "R1 cfg0");
        rd_chk(cfg(3), 32'h8, "R1 cfg3");
        out_chk(1, 0, "R1 wake_irq");
        out_chk(2, 0, "R1 wake_req");
        out_chk(3, 0, "R1 perip_out");

        // R2 map and unimplemented bits
        bus_wr(A_EN, 32'hFFFF_FFFF);
        rd_chk(A_EN, 32'h0000_000F, "R2 enable width");
        bus_wr(A_RT, 32'hFFFF_FFFF);
        rd_chk(A_RT, 32'h0F07_0F07, "R2 route fields");
        rd_chk(A_CL, 32'h0, "R2 clear reads zero");
        rd_chk(12'h320, 32'h0, "R2 unmapped");
        bus_wr(cfg(1), 32'hFFFF_FFFF);
        rd_chk(cfg(1), 32'h1E, "R2 cfg1 fields");
        bus_wr(cfg(1), 32'h8);
        bus_wr(A_RT, 32'h0);
        bus_wr(A_EN, 32'h0);

        // R9 pass-through
        perip_in = 3'b101;
        out_chk(3, 0, "R9 unrouted");
        bus_wr(A_RT, 32'h5);
        out_chk(3, 32'h5, "R9 routed");
        perip_in = 3'b011;
        out_chk(3, 32'h1, "R9 follows level");

        // R10 peripheral wake
        bus_wr(A_RT, 32'h0002_0000);
        perip_in = 3'b010;
        out_chk(2, 1, "R10 perip wake");
        perip_in = 3'b001;
        out_chk(2, 0, "R10 perip not enabled");
        perip_in = '0;
        bus_wr(A_RT, 32'h0);

        // R3 level readback timing
        @(negedge clk);
        wake_pin[2] = 1'b1;
        rd_chk(cfg(2), 32'h8, "R3 after one edge");
        rd_chk(cfg(2), 32'h9, "R3 after two edges");
        rd_chk(A_ST, 32'h0, "R6 mode 4 no status");

        // R4 level-high on pin 2, routing R8 R10
        bus_wr(cfg(2), 32'h2);
        idle(2);
        rd_chk(A_ST, 32'h4, "R4 level high");
        rd_chk(cfg(2), 32'h3, "R2 cfg2 mode readback");
        bus_wr(A_EN, 32'h4);
        out_chk(1, 0, "R8 enabled but not routed");
        bus_wr(A_RT, 32'h400);
        out_chk(1, 1, "R8 enabled and routed");
        bus_wr(A_EN, 32'h0);
        out_chk(1, 0, "R8 disabled");
        bus_wr(A_RT, 32'h0400_0000);
        out_chk(2, 1, "R10 pin wake without enable");
        out_chk(1, 0, "R8 wake route only");
        bus_wr(A_RT, 32'h0);
        out_chk(2, 0, "R10 no route");
        bus_wr(A_CL, 32'h4);
        rd_chk(A_ST, 32'h4, "R4 reasserts while high");
        bus_wr(cfg(2), 32'h8);
        bus_wr(A_CL, 32'h4);
        rd_chk(A_ST, 32'h0, "R7 clear after mode off");
        @(negedge clk);
        wake_pin[2] = 1'b0;

        // R4 level-low on pin 0
        bus_wr(cfg(0), 32'h0);
        idle(2);
        rd_chk(A_ST, 32'h1, "R4 level low");
        bus_wr(cfg(0), 32'h8);
        bus_wr(A_CL, 32'h1);
        rd_chk(A_ST, 32'h0, "R4 cleared");

        // R5 rising on pin 1, exact latency
        bus_wr(cfg(1), 32'h6);
        @(negedge clk);
        wake_pin[1] = 1'b1;
        rd_chk(A_ST, 32'h0, "R5 rise edge1");
        rd_chk(A_ST, 32'h0, "R5 rise edge2");
        rd_chk(A_ST, 32'h2, "R5 rise edge3");
        bus_wr(A_CL, 32'h2);
        rd_chk(A_ST, 32'h0, "R5 no reassert");
        @(negedge clk);
        wake_pin[1] = 1'b0;
        idle(4);
        rd_chk(A_ST, 32'h0, "R5 falling ignored in rise mode");

        // R5 falling on pin 3
        @(negedge clk);
        wake_pin[3] = 1'b1;
        idle(4);
        bus_wr(cfg(3), 32'h4);
        @(negedge clk);
        wake_pin[3] = 1'b0;
        idle(4);
        rd_chk(A_ST, 32'h8, "R5 falling");
        bus_wr(A_CL, 32'h8);
        rd_chk(A_ST, 32'h0, "R5 falling cleared");
        bus_wr(cfg(3), 32'h8);

        // R5 either edge on pin 0
        bus_wr(cfg(0), 32'hC);
        @(negedge clk);
        wake_pin[0] = 1'b1;
        idle(4);
        rd_chk(A_ST, 32'h1, "R5 any rise");
        bus_wr(A_CL, 32'h1);
        rd_chk(A_ST, 32'h0, "R5 any cleared");
        @(negedge clk);
        wake_pin[0] = 1'b0;
        idle(4);
        rd_chk(A_ST, 32'h1, "R5 any fall");
        bus_wr(A_CL, 32'h1);

        // R7 selective clear
        @(negedge clk);
        wake_pin[0] = 1'b1;
        wake_pin[1] = 1'b1;
        idle(4);
        rd_chk(A_ST, 32'h3, "R7 two sources");
        bus_wr(A_CL, 32'h1);
        rd_chk(A_ST, 32'h2, "R7 only bit0 cleared");

        // R12 status writes ignored
        bus_wr(A_ST, 32'hF);
        rd_chk(A_ST, 32'h2, "R12 status write ignored");
        bus_wr(A_ST, 32'h0);
        rd_chk(A_ST, 32'h2, "R12 status zero write ignored");
        bus_wr(A_CL, 32'hF);
        rd_chk(A_ST, 32'h0, "R7 clear all");

        // R11 hold bit
        bus_wr(cfg(1), 32'h16);
        @(negedge clk);
        wake_pin[1] = 1'b0;
        idle(4);
        @(negedge clk);
        wake_pin[1] = 1'b1;
        idle(4);
        rd_chk(A_ST, 32'h0, "R11 held no event");
        rd_chk(cfg(1), 32'h17, "R11 cfg readback");
        bus_wr(cfg(1), 32'h6);
        idle(4);
        rd_chk(A_ST, 32'h0, "R11 no stale edge");

        // R6 unused codes
        bus_wr(cfg(2), 32'hA);
        @(negedge clk);
        wake_pin[2] = 1'b1;
        idle(4);
        rd_chk(A_ST, 32'h0, "R6 code 5 high");
        @(negedge clk);
        wake_pin[2] = 1'b0;
        idle(4);
        rd_chk(A_ST, 32'h0, "R6 code 5 low");
        bus_wr(cfg(2), 32'hE);
        rd_chk(cfg(2), 32'hE, "R2 cfg2 code 7");
        @(negedge clk);
        wake_pin[2] = 1'b1;
        idle(4);
        rd_chk(A_ST, 32'h0, "R6 code 7");

        idle(3);
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual run still busy, expected finished");
            finish_run();
        end
    end
endmodule